// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the bus-facing register file of an SPI master. Software reaches it through a simple 32-bit bus with an address, a write strobe with write data, and a read strobe with read data. It holds a control word, a second control word with fault enables, a baud divisor and a status word. The control words can be changed atomically through set and clear alias addresses. The data address leads into two FIFOs. Writing the data address loads the transmit FIFO, and reading it unloads the receive FIFO.

The shift engine sits on the far side. It pops transmit words, pushes received words, and reports its shifter state, its busy state, and pulses for underrun and frame errors. Each FIFO holds a fixed 16 bytes, so the number of entries it can hold depends on the word width chosen in the control word. Three level-sensitive interrupts are produced. Two of them follow FIFO-level conditions that software selects. The third follows whichever sticky error flags software has enabled.

Top module: `spi_regfront`

## Requirements
- R1: After synchronous reset, every register is zero and both FIFOs are empty. A status read returns 0x000000A8 while the shifter reports empty. `irq_rx` and `irq_tx` are 1, because both condition selects are 0 and both FIFOs are empty. `irq_fault` is 0.
- R2: Byte addresses are: control 0x00, control-clear 0x04, control-set 0x08, status 0x10, status-clear 0x14, data 0x20, baud 0x30, control-2 0x40, control-2-clear 0x44 and control-2-set 0x48. A write to a base address replaces the register. A write to a clear alias clears each bit written as 1. A write to a set alias sets each bit written as 1. No other bit changes.
- R3: Control bits 11:10 select the word width: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. Words written to the data address are masked to that width and reach `eng_tx_data` in write order.
- R4: Each FIFO holds 16, 8 or 4 entries for widths of 8, 16 or 32 bits. A data write while the transmit FIFO is full is dropped.
- R5: A data read returns the oldest received word, masked to the width, and pops it. A data read while the receive FIFO is empty returns 0 and changes nothing.
- R6: A receive push while the receive FIFO is full drops the word and sets the sticky overflow flag in status bit 6. Only a status-clear write with bit 6 set clears that flag.
- R7: An `eng_underrun` pulse sets sticky status bit 8, and an `eng_frame_err` pulse sets sticky status bit 12. Each is cleared by a status-clear write of that bit.
- R8: Status layout: bit 0 is RX full, bit 1 TX full, bit 3 TX empty, bit 5 RX empty, bit 6 overflow, bit 7 shifter empty, bit 8 underrun, bit 11 busy, bit 12 frame error. Bits 20:16 hold the TX fill level and bits 28:24 the RX fill level. All other bits read 0.
- R9: `irq_rx` follows control bits 1:0. Select 0 means RX empty, 1 means not empty, 2 means fill×2 ≥ capacity, and 3 means full.
- R10: `irq_tx` follows control bits 3:2. Select 0 means TX empty and shifter empty, 1 means TX empty, 2 means free×2 ≥ capacity, and 3 means at least one free entry.
- R11: `irq_fault` is the OR of three terms: underrun AND control-2 bit 10, overflow AND control-2 bit 11, and frame error AND control-2 bit 12.
- R12: The baud register keeps only 9 bits, and its upper bits read 0. Writes to the status base address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops RX at the data address |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| eng_tx_pop | input | 1 | Engine takes the TX head |
| eng_tx_data | output | 32 | TX head word |
| eng_tx_valid | output | 1 | TX FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_shift_empty | input | 1 | Engine shifter holds no data |
| eng_busy | input | 1 | Engine is transferring |
| eng_underrun | input | 1 | Underrun event pulse |
| eng_frame_err | input | 1 | Frame error event pulse |
| cfg_ctrl | output | 32 | Control register |
| cfg_ctrl2 | output | 32 | Control-2 register |
| cfg_baud | output | 9 | Baud divisor |
| irq_rx | output | 1 | Receive interrupt level |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_fault | output | 1 | Fault interrupt level |

## Verification
The assertions assume three things about the inputs. First, the engine pulses an event input for one cycle per event. Second, the engine pops only when `eng_tx_valid` is high or accepts that the pop is ignored. Third, no read and write target the data address in the same cycle. The directed stimulus keeps within these limits. It drives every strobe for exactly one cycle, between falling edges. It never pairs a bus read with a bus write. It changes the word width only while both FIFOs are empty, so a capacity change never meets a fill level above the new capacity.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam int FIFO_BYTES = 16;
    localparam int LVL_W      = $clog2(FIFO_BYTES + 1);
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL      = 8'h00,
        ADR_CTRL_CLR  = 8'h04,
        ADR_CTRL_SET  = 8'h08,
        ADR_STAT      = 8'h10,
        ADR_STAT_CLR  = 8'h14,
        ADR_DATA      = 8'h20,
        ADR_BAUD      = 8'h30,
        ADR_CTRL2     = 8'h40,
        ADR_CTRL2_CLR = 8'h44,
        ADR_CTRL2_SET = 8'h48
    } reg_addr_e;

    typedef enum logic [1:0] {
        WS_8   = 2'd0,
        WS_16  = 2'd1,
        WS_32  = 2'd2,
        WS_32B = 2'd3
    } wsize_e;

    // control field positions
    localparam int CTL_RXSEL_LSB = 0;
    localparam int CTL_TXSEL_LSB = 2;
    localparam int CTL_WS_LSB    = 10;
    // control-2 fault enables
    localparam int EN_UNDER_BIT  = 10;
    localparam int EN_OVF_BIT    = 11;
    localparam int EN_FRAME_BIT  = 12;
    // sticky status bits
    localparam int ST_OVF_BIT    = 6;
    localparam int ST_UNDER_BIT  = 8;
    localparam int ST_FRAME_BIT  = 12;

    typedef struct packed {
        logic frame_err;
        logic underrun;
        logic rx_ovf;
    } sticky_t;

    function automatic logic [LVL_W-1:0] cap_of(input logic [1:0] ws);
        case (wsize_e'(ws))
            WS_8:    return LVL_W'(FIFO_BYTES);
            WS_16:   return LVL_W'(FIFO_BYTES / 2);
            default: return LVL_W'(FIFO_BYTES / 4);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] mask_of(input logic [1:0] ws);
        case (wsize_e'(ws))
            WS_8:    return DATA_W'(32'h0000_00FF);
            WS_16:   return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    // true when twice the amount reaches the capacity
    function automatic logic half_or_more(input logic [LVL_W-1:0] amt,
                                          input logic [LVL_W-1:0] cap);
        return {amt, 1'b0} >= {1'b0, cap};
    endfunction

endpackage

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = cnt >= cap;
    assign empty   = cnt == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= pdata;
    end

    AST_PUSH_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt == $past(cnt)));           // R4
    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (cnt == $past(cnt)));          // R5

endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
    import spi_regfront_pkg::*;
(
    input  logic [1:0]       rx_sel,
    input  logic [1:0]       tx_sel,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] cap,
    input  logic             shift_empty,
    input  sticky_t          flags,
    input  logic [2:0]       fault_en,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             irq_fault
);
    logic [LVL_W-1:0] tx_free;

    assign tx_free = (cap > tx_lvl) ? cap - tx_lvl : '0;

    always_comb begin
        case (rx_sel)
            2'd0:    irq_rx = rx_lvl == '0;
            2'd1:    irq_rx = rx_lvl != '0;
            2'd2:    irq_rx = half_or_more(rx_lvl, cap);
            default: irq_rx = rx_lvl >= cap;
        endcase
        case (tx_sel)
            2'd0:    irq_tx = (tx_lvl == '0) && shift_empty;
            2'd1:    irq_tx = tx_lvl == '0;
            2'd2:    irq_tx = half_or_more(tx_free, cap);
            default: irq_tx = tx_lvl < cap;
        endcase
    end

    // fault_en order: {frame, overflow, underrun}
    assign irq_fault = |({flags.frame_err, flags.rx_ovf, flags.underrun} & fault_en);

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int BAUD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_shift_empty,
    input  logic              eng_busy,
    input  logic              eng_underrun,
    input  logic              eng_frame_err,
    output logic [DATA_W-1:0] cfg_ctrl,
    output logic [DATA_W-1:0] cfg_ctrl2,
    output logic [BAUD_W-1:0] cfg_baud,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_fault
);
    logic [DATA_W-1:0] ctrl_q, ctrl2_q, ctrl_d, ctrl2_d, wmask, stat;
    logic [BAUD_W-1:0] baud_q;
    sticky_t           err_q, err_d;
    logic [LVL_W-1:0]  cap, tx_lvl, rx_lvl;
    logic [DATA_W-1:0] rx_head;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_push, rx_pop, stat_clr_wr;
    logic [1:0]        wsel;

    assign wsel        = ctrl_q[CTL_WS_LSB +: 2];
    assign cap         = cap_of(wsel);
    assign wmask       = mask_of(wsel);
    assign tx_push     = bus_wr && (bus_addr == ADR_DATA);
    assign rx_pop      = bus_rd && (bus_addr == ADR_DATA);
    assign stat_clr_wr = bus_wr && (bus_addr == ADR_STAT_CLR);

    spi_rf_fifo #(.DEPTH(FIFO_BYTES), .W(DATA_W)) i_tx_fifo (
        .clk, .rst, .cap,
        .push(tx_push), .pdata(bus_wdata & wmask), .pop(eng_tx_pop),
        .head(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    spi_rf_fifo #(.DEPTH(FIFO_BYTES), .W(DATA_W)) i_rx_fifo (
        .clk, .rst, .cap,
        .push(eng_rx_push), .pdata(eng_rx_data & wmask), .pop(rx_pop),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    // register writes with set/clear aliases
    always_comb begin
        ctrl_d  = ctrl_q;
        ctrl2_d = ctrl2_q;
        if (bus_wr) begin
            case (bus_addr)
                ADR_CTRL:      ctrl_d  = bus_wdata;
                ADR_CTRL_CLR:  ctrl_d  = ctrl_q & ~bus_wdata;
                ADR_CTRL_SET:  ctrl_d  = ctrl_q | bus_wdata;
                ADR_CTRL2:     ctrl2_d = bus_wdata;
                ADR_CTRL2_CLR: ctrl2_d = ctrl2_q & ~bus_wdata;
                ADR_CTRL2_SET: ctrl2_d = ctrl2_q | bus_wdata;
                default: ;
            endcase
        end
    end

    // sticky flags: a new event wins over a clear in the same cycle
    always_comb begin
        err_d.rx_ovf    = (err_q.rx_ovf && !(stat_clr_wr && bus_wdata[ST_OVF_BIT]))
                          || (eng_rx_push && rx_full);
        err_d.underrun  = (err_q.underrun && !(stat_clr_wr && bus_wdata[ST_UNDER_BIT]))
                          || eng_underrun;
        err_d.frame_err = (err_q.frame_err && !(stat_clr_wr && bus_wdata[ST_FRAME_BIT]))
                          || eng_frame_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ctrl2_q <= '0;
            baud_q  <= '0;
            err_q   <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            ctrl2_q <= ctrl2_d;
            err_q   <= err_d;
            if (bus_wr && (bus_addr == ADR_BAUD))
                baud_q <= bus_wdata[BAUD_W-1:0];
        end
    end

    always_comb begin
        stat                  = '0;
        stat[0]               = rx_full;
        stat[1]               = tx_full;
        stat[3]               = tx_empty;
        stat[5]               = rx_empty;
        stat[ST_OVF_BIT]      = err_q.rx_ovf;
        stat[7]               = eng_shift_empty;
        stat[ST_UNDER_BIT]    = err_q.underrun;
        stat[11]              = eng_busy;
        stat[ST_FRAME_BIT]    = err_q.frame_err;
        stat[16 +: LVL_W]     = tx_lvl;
        stat[24 +: LVL_W]     = rx_lvl;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADR_CTRL:  bus_rdata = ctrl_q;
                ADR_CTRL2: bus_rdata = ctrl2_q;
                ADR_STAT:  bus_rdata = stat;
                ADR_BAUD:  bus_rdata = DATA_W'(baud_q);
                ADR_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
                default:   bus_rdata = '0;
            endcase
        end
    end

    spi_rf_irq i_irq (
        .rx_sel(ctrl_q[CTL_RXSEL_LSB +: 2]),
        .tx_sel(ctrl_q[CTL_TXSEL_LSB +: 2]),
        .rx_lvl, .tx_lvl, .cap,
        .shift_empty(eng_shift_empty),
        .flags(err_q),
        .fault_en({ctrl2_q[EN_FRAME_BIT], ctrl2_q[EN_OVF_BIT], ctrl2_q[EN_UNDER_BIT]}),
        .irq_rx, .irq_tx, .irq_fault
    );

    assign cfg_ctrl  = ctrl_q;
    assign cfg_ctrl2 = ctrl2_q;
    assign cfg_baud  = baud_q;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_full) |=> err_q.rx_ovf);                          // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q.rx_ovf && !(stat_clr_wr && bus_wdata[ST_OVF_BIT])) |=> err_q.rx_ovf); // R6
    AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ctrl2_q[EN_FRAME_BIT:EN_UNDER_BIT] == 3'b000) |-> !irq_fault);      // R11
    AST_RX_FULL_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q[1:0] == 2'd3) && irq_rx) |-> rx_full);                       // R9
    AST_TX_EMPTY_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q[3:2] == 2'd1) && irq_tx) |-> tx_empty);                      // R10
    AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == ADR_BAUD)) |=> $stable(baud_q));             // R12

endmodule

// File: tb/test_spi_regfront.sv
module test_spi_regfront;
    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_CTRL = 8'h00, A_CCLR = 8'h04, A_CSET = 8'h08,
                           A_STAT = 8'h10, A_SCLR = 8'h14, A_DATA = 8'h20,
                           A_BAUD = 8'h30, A_C2 = 8'h40, A_C2CLR = 8'h44,
                           A_C2SET = 8'h48;

    logic        clk = 0, rst = 1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        eng_tx_pop = 0, eng_tx_valid, eng_rx_push = 0;
    logic [31:0] eng_tx_data, eng_rx_data = '0;
    logic        eng_shift_empty = 1, eng_busy = 0, eng_underrun = 0, eng_frame_err = 0;
    logic [31:0] cfg_ctrl, cfg_ctrl2;
    logic [8:0]  cfg_baud;
    logic        irq_rx, irq_tx, irq_fault;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    spi_regfront i_spi_regfront (
        .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
        .eng_tx_pop, .eng_tx_data, .eng_tx_valid, .eng_rx_push, .eng_rx_data,
        .eng_shift_empty, .eng_busy, .eng_underrun, .eng_frame_err,
        .cfg_ctrl, .cfg_ctrl2, .cfg_baud, .irq_rx, .irq_tx, .irq_fault
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0; #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1; d = bus_rdata;
        @(negedge clk); bus_rd = 0; #1;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk); eng_rx_data = d; eng_rx_push = 1;
        @(negedge clk); eng_rx_push = 0; #1;
    endtask

    task automatic eng_pop(input bit check, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        if (check) begin
            chk({tag, " valid"}, 32'(eng_tx_valid), 32'd1);
            chk({tag, " data"}, eng_tx_data, exp);
        end
        eng_tx_pop = 1;
        @(negedge clk); eng_tx_pop = 0; #1;
    endtask

    task automatic pulse(input bit frame);
        @(negedge clk);
        if (frame) eng_frame_err = 1; else eng_underrun = 1;
        @(negedge clk); eng_frame_err = 0; eng_underrun = 0; #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
        rd(A_C2, d);    chk("R1 ctrl2", d, 32'h0);
        rd(A_STAT, d);  chk("R1 status", d, 32'h0000_00A8);
        chk("R1 irq_rx", 32'(irq_rx), 32'd1);
        chk("R1 irq_tx", 32'(irq_tx), 32'd1);
        chk("R1 irq_fault", 32'(irq_fault), 32'd0);
    endtask

    task automatic t_alias;
        logic [31:0] d;
        wr(A_CTRL, 32'h0000_00F0);
        wr(A_CSET, 32'h0000_0005);
        wr(A_CCLR, 32'h0000_0030);
        rd(A_CTRL, d); chk("R2 ctrl set/clear", d, 32'h0000_00C5);
        chk("R2 cfg_ctrl port", cfg_ctrl, 32'h0000_00C5);
        wr(A_C2SET, 32'h0000_1C00);
        wr(A_C2CLR, 32'h0000_0800);
        rd(A_C2, d); chk("R2 ctrl2 set/clear", d, 32'h0000_1400);
        rd(A_CTRL, d); chk("R2 ctrl untouched", d, 32'h0000_00C5);
        wr(A_CTRL, 32'h0); wr(A_C2, 32'h0);
    endtask

    task automatic t_baud_stat;
        logic [31:0] d;
        wr(A_BAUD, 32'hFFFF_FFFF);
        rd(A_BAUD, d); chk("R12 baud width", d, 32'h0000_01FF);
        chk("R12 cfg_baud", 32'(cfg_baud), 32'h1FF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R12 status write ignored", d, 32'h0000_00A8);
        eng_busy = 1; #1;
        rd(A_STAT, d); chk("R8 busy bit11", d, 32'h0000_08A8);
        eng_busy = 0;
    endtask

    task automatic t_tx(input logic [1:0] ws, input int cap, input logic [31:0] base,
                        input logic [31:0] mask, input string tag);
        logic [31:0] d;
        wr(A_CTRL, 32'(ws) << 10);
        for (int i = 0; i <= cap; i++) wr(A_DATA, base + 32'(i));
        rd(A_STAT, d);
        chk({tag, " R4 tx level"}, 32'(d[20:16]), 32'(cap));
        chk({tag, " R8 tx full/empty bits"}, {30'h0, d[3], d[1]}, 32'h1);
        for (int i = 0; i < cap; i++)
            eng_pop(1, (base + 32'(i)) & mask, {tag, " R3 order"});
        chk({tag, " R4 overflow dropped"}, 32'(eng_tx_valid), 32'd0);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        wr(A_CTRL, 32'h0);
        eng_push(32'h1111_11A1); eng_push(32'h2222_22B2); eng_push(32'h3333_33C3);
        rd(A_STAT, d); chk("R8 rx level", 32'(d[28:24]), 32'd3);
        rd(A_DATA, d); chk("R5 rx first", d, 32'hA1);
        rd(A_DATA, d); chk("R5 rx second", d, 32'hB2);
        rd(A_DATA, d); chk("R5 rx third", d, 32'hC3);
        rd(A_DATA, d); chk("R5 empty read zero", d, 32'h0);
        rd(A_STAT, d); chk("R5 empty read no effect", d, 32'h0000_00A8);
    endtask

    task automatic t_ovf;
        logic [31:0] d;
        wr(A_CTRL, 32'h0000_0800);
        for (int i = 0; i < 5; i++) eng_push(32'hC0DE_0000 + 32'(i));
        rd(A_STAT, d);
        chk("R6 ovf set", 32'(d[6]), 32'd1);
        chk("R4 rx cap 4", 32'(d[28:24]), 32'd4);
        chk("R8 rx full bit0", 32'(d[0]), 32'd1);
        for (int i = 0; i < 4; i++) begin
            rd(A_DATA, d); chk("R6 rx kept words", d, 32'hC0DE_0000 + 32'(i));
        end
        rd(A_STAT, d); chk("R6 ovf sticky after drain", 32'(d[6]), 32'd1);
        wr(A_SCLR, 32'h0000_0100);
        rd(A_STAT, d); chk("R6 other clear bit keeps ovf", 32'(d[6]), 32'd1);
        wr(A_SCLR, 32'h0000_0040);
        rd(A_STAT, d); chk("R6 ovf cleared", 32'(d[6]), 32'd0);
    endtask

    task automatic t_fault;
        logic [31:0] d;
        wr(A_C2SET, 32'h0000_0800);
        chk("R11 enabled no flag", 32'(irq_fault), 32'd0);
        for (int i = 0; i < 5; i++) eng_push(32'h0);
        chk("R11 ovf raises fault", 32'(irq_fault), 32'd1);
        for (int i = 0; i < 4; i++) rd(A_DATA, d);
        wr(A_C2CLR, 32'h0000_0800);
        chk("R11 ovf masked", 32'(irq_fault), 32'd0);
        wr(A_SCLR, 32'h0000_0040);
        pulse(0);
        chk("R11 underrun masked", 32'(irq_fault), 32'd0);
        rd(A_STAT, d); chk("R7 underrun bit8", 32'(d[8]), 32'd1);
        wr(A_C2SET, 32'h0000_0400);
        chk("R11 underrun enabled", 32'(irq_fault), 32'd1);
        wr(A_SCLR, 32'h0000_0100);
        chk("R7 underrun cleared", 32'(irq_fault), 32'd0);
        wr(A_C2, 32'h0000_1000);
        pulse(1);
        chk("R11 frame enabled", 32'(irq_fault), 32'd1);
        rd(A_STAT, d); chk("R7 frame bit12", 32'(d[12]), 32'd1);
        wr(A_SCLR, 32'h0000_1000);
        chk("R7 frame cleared", 32'(irq_fault), 32'd0);
        wr(A_C2, 32'h0);
    endtask

    task automatic t_rx_irq;
        logic [31:0] d;
        wr(A_CTRL, 32'h1);  chk("R9 sel1 empty", 32'(irq_rx), 32'd0);
        eng_push(32'h5);     chk("R9 sel1 one", 32'(irq_rx), 32'd1);
        wr(A_CTRL, 32'h2);  chk("R9 sel2 one of 16", 32'(irq_rx), 32'd0);
        for (int i = 0; i < 7; i++) eng_push(32'h5);
        chk("R9 sel2 eight of 16", 32'(irq_rx), 32'd1);
        wr(A_CTRL, 32'h3);  chk("R9 sel3 eight", 32'(irq_rx), 32'd0);
        for (int i = 0; i < 8; i++) eng_push(32'h5);
        chk("R9 sel3 full", 32'(irq_rx), 32'd1);
        wr(A_CTRL, 32'h0);  chk("R9 sel0 not empty", 32'(irq_rx), 32'd0);
        for (int i = 0; i < 16; i++) rd(A_DATA, d);
        chk("R9 sel0 empty", 32'(irq_rx), 32'd1);
    endtask

    task automatic t_tx_irq;
        wr(A_CTRL, 32'h0);   chk("R10 sel0 all empty", 32'(irq_tx), 32'd1);
        eng_shift_empty = 0; #1;
        chk("R10 sel0 shifter busy", 32'(irq_tx), 32'd0);
        wr(A_CTRL, 32'h4);   chk("R10 sel1 empty", 32'(irq_tx), 32'd1);
        wr(A_DATA, 32'h1);   chk("R10 sel1 one word", 32'(irq_tx), 32'd0);
        wr(A_CTRL, 32'h8);   chk("R10 sel2 free 15", 32'(irq_tx), 32'd1);
        for (int i = 0; i < 7; i++) wr(A_DATA, 32'h1);
        chk("R10 sel2 free 8", 32'(irq_tx), 32'd1);
        wr(A_DATA, 32'h1);   chk("R10 sel2 free 7", 32'(irq_tx), 32'd0);
        wr(A_CTRL, 32'hC);   chk("R10 sel3 free 7", 32'(irq_tx), 32'd1);
        for (int i = 0; i < 7; i++) wr(A_DATA, 32'h1);
        chk("R10 sel3 full", 32'(irq_tx), 32'd0);
        eng_shift_empty = 1;
        for (int i = 0; i < 16; i++) eng_pop(0, 32'h0, "");
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; #1;
        t_reset;
        t_alias;
        t_baud_stat;
        t_tx(2'd0, 16, 32'h1234_56A0, 32'h0000_00FF, "w8");
        t_tx(2'd1, 8,  32'hABCD_1230, 32'h0000_FFFF, "w16");
        t_tx(2'd2, 4,  32'hDEAD_BE00, 32'hFFFF_FFFF, "w32");
        t_rx;
        t_ovf;
        t_fault;
        t_rx_irq;
        t_tx_irq;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule